// File: doc/BRIEF.md
# Buffered Configuration-Port Transfer Engine

This block is a bus-attached peripheral that holds up to 512 words of 32 bits in an on-chip staging buffer and moves a contiguous run of them, as one burst, either out to a device configuration port or in from it. A host fills the buffer through the bus and sets a byte length and a starting word index. It then writes the direction register, and that write both picks the direction and launches the burst. While the burst runs, the done flag in the status word reads 0.

The configuration port is word-wide. In the configure direction it is a valid/ready source driven by the engine. In the readback direction it is a valid/ready sink that the engine drains into the buffer. Four port condition inputs are reported in the status word beside the done flag. Any write to the status word aborts a running burst.

Bus reads return data one cycle after the request, with a strobe. The byte map is as follows. The buffer sits below 0x800, with word N at byte N*4. The length register is at 0x800, the start index at 0x804, the direction register at 0x808 and the status word at 0x80C.

Top module: `cfg_burst_engine`

## Requirements
- R1: A bus write below byte 0x800 stores the data in buffer word address[10:2]. A bus read request of any address raises `bus_rvalid` on the next cycle, and for a buffer address that cycle also carries the stored word on `bus_rdata`.
- R2: The length register (0x800) and the start-index register (0x804) keep all 32 written bits and read them back. Reads of the direction register (0x808) return 0.
- R3: Writing 0x808 with bit 0 = 0 starts a configure burst, and with bit 0 = 1 starts a readback burst. The burst moves length/4 words, and the two low length bits are ignored. A status read in the cycle after the start write shows done = 0 whenever the word count is not zero.
- R4: The status word (0x80C) carries done in bit 0 and ones in bits 4..1. Bit 5 mirrors `port_abort_n`, bit 6 `port_rip`, bit 7 `port_dalign` and bit 8 `port_cfgerr`. All higher bits are 0.
- R5: A configure burst presents buffer words start, start+1, … in order on `cfg_out_data` with `cfg_out_valid`. Each word is held stable until `cfg_out_ready` accepts it.
- R6: A readback burst writes the word of each `cfg_in_valid`/`cfg_in_ready` handshake to buffer word start+i, for i = 0, 1, …. `cfg_in_ready` and `cfg_out_valid` are never high together.
- R7: A burst whose start plus count passes word 511 stops after word 511. A start index of 512 or more moves no words.
- R8: A word count of 0 moves nothing, and done stays 1. Done only falls on a start write.
- R9: A write to 0x808 while a burst is running is ignored. It changes neither the direction nor the number of words moved.
- R10: Any write to 0x80C returns the engine to idle on the next cycle, with done = 1 and no further handshakes. A port handshake in the same cycle as that write still counts.
- R11: After reset both registers read 0, done is 1, and `cfg_out_valid` and `cfg_in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| cfg_out_valid | output | 1 | Configure word valid |
| cfg_out_data | output | 32 | Configure word |
| cfg_out_ready | input | 1 | Port accepts configure word |
| cfg_in_valid | input | 1 | Readback word valid |
| cfg_in_data | input | 32 | Readback word |
| cfg_in_ready | output | 1 | Engine accepts readback word |
| port_abort_n | input | 1 | Port abort condition, active low |
| port_rip | input | 1 | Port readback in progress |
| port_dalign | input | 1 | Port data aligned |
| port_cfgerr | input | 1 | Port configuration error |

## Verification
Two events can coincide: the abort write to the status word and a readback handshake that the port completes on the same clock edge. The bench drives the port with `cfg_in_valid` held high throughout a readback. It places the abort write on the edge where the next word is accepted, and that word is recorded as transferred. Afterwards it reads the buffer back. Every recorded word must be present, and the word just past the last recorded one must still hold its old contents. The same idea is applied to a second start write that lands during a stalled configure burst.

// File: rtl/cbe_pkg.sv
package cbe_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_FETCH = 2'd1,
        ENG_SEND  = 2'd2,
        ENG_RECV  = 2'd3
    } eng_state_e;

    // register select = byte address bits [3:2] inside the register window
    localparam logic [1:0] SEL_LENGTH = 2'd0;
    localparam logic [1:0] SEL_START  = 2'd1;
    localparam logic [1:0] SEL_DIR    = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    localparam int STAT_ONES_LSB = 1;
    localparam int STAT_ONES_MSB = 4;
    localparam int STAT_ABORT    = 5;
    localparam int STAT_RIP      = 6;
    localparam int STAT_DALIGN   = 7;
    localparam int STAT_CFGERR   = 8;
endpackage

// File: rtl/cbe_buffer.sv
module cbe_buffer #(
    parameter int WW    = 32,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [WW-1:0] a_wdata,
    output logic [WW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [WW-1:0] b_wdata,
    output logic [WW-1:0] b_rdata
);
    logic [WW-1:0] mem [DEPTH];

    // engine port B is written last, so it wins an address collision
    always_ff @(posedge clk) begin
        if (a_en) begin
            if (a_we) mem[a_addr] <= a_wdata;
            a_rdata <= mem[a_addr];
        end
        if (b_en) begin
            if (b_we) mem[b_addr] <= b_wdata;
            b_rdata <= mem[b_addr];
        end
    end
endmodule

// File: rtl/cbe_engine.sv
module cbe_engine
    import cbe_pkg::*;
#(
    parameter int WW = 32,
    parameter int AW = 9,
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_rb,
    input  logic [AW-1:0] start_off,
    input  logic [CW-1:0] start_cnt,
    input  logic          abort,
    output logic          done,
    output logic          out_valid,
    output logic [WW-1:0] out_data,
    input  logic          out_ready,
    input  logic          in_valid,
    input  logic [WW-1:0] in_data,
    output logic          in_ready,
    output logic          b_en,
    output logic          b_we,
    output logic [AW-1:0] b_addr,
    output logic [WW-1:0] b_wdata,
    input  logic [WW-1:0] b_rdata
);
    typedef struct packed {
        eng_state_e    st;
        logic [CW-1:0] idx;
        logic [CW-1:0] cnt;
        logic [AW-1:0] base;
    } eng_t;

    eng_t          eng_d, eng_q;
    logic [CW-1:0] idx_inc;
    logic          last_word;

    always_comb begin
        eng_d     = eng_q;
        idx_inc   = CW'(eng_q.idx + 1'b1);
        last_word = (idx_inc == eng_q.cnt);
        b_en      = 1'b0;
        b_we      = 1'b0;
        b_addr    = eng_q.base + eng_q.idx[AW-1:0];
        b_wdata   = in_data;
        unique case (eng_q.st)
            ENG_IDLE: begin
                if (start && start_cnt != '0) begin
                    eng_d.base = start_off;
                    eng_d.cnt  = start_cnt;
                    eng_d.idx  = '0;
                    eng_d.st   = dir_rb ? ENG_RECV : ENG_FETCH;
                end
            end
            ENG_FETCH: begin
                b_en     = 1'b1;
                eng_d.st = ENG_SEND;
            end
            ENG_SEND: begin
                if (out_ready) begin
                    eng_d.idx = idx_inc;
                    eng_d.st  = last_word ? ENG_IDLE : ENG_FETCH;
                end
            end
            ENG_RECV: begin
                if (in_valid) begin
                    b_en      = 1'b1;
                    b_we      = 1'b1;
                    eng_d.idx = idx_inc;
                    if (last_word) eng_d.st = ENG_IDLE;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
        // abort wins over the state step, but a write issued above still lands
        if (abort) eng_d.st = ENG_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ENG_IDLE, idx: '0, cnt: '0, base: '0};
        else        eng_q <= eng_d;
    end

    assign done      = (eng_q.st == ENG_IDLE);
    assign out_valid = (eng_q.st == ENG_SEND);
    assign in_ready  = (eng_q.st == ENG_RECV);
    assign out_data  = b_rdata;
endmodule

// File: rtl/cfg_burst_engine.sv
module cfg_burst_engine
    import cbe_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BUF_WORDS = 512,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              cfg_out_valid,
    output logic [WORD_W-1:0] cfg_out_data,
    input  logic              cfg_out_ready,
    input  logic              cfg_in_valid,
    input  logic [WORD_W-1:0] cfg_in_data,
    output logic              cfg_in_ready,
    input  logic              port_abort_n,
    input  logic              port_rip,
    input  logic              port_dalign,
    input  logic              port_cfgerr
);
    localparam int AW       = $clog2(BUF_WORDS);
    localparam int CW       = AW + 1;
    localparam int REG_BASE = BUF_WORDS * 4;

    typedef struct packed {
        logic [WORD_W-1:0] length;
        logic [WORD_W-1:0] first;
        logic              rvalid;
        logic              from_buf;
        logic [WORD_W-1:0] rword;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic              is_reg;
    logic [1:0]        reg_sel;
    logic              buf_en;
    logic [WORD_W-1:0] buf_rdata;
    logic              eng_start, eng_abort, eng_done;
    logic [WORD_W-1:0] status_word;
    logic              first_ok, words_over;
    logic [CW-1:0]     room, start_cnt;
    logic              b_en, b_we;
    logic [AW-1:0]     b_addr;
    logic [WORD_W-1:0] b_wdata, b_rdata;

    always_comb begin
        is_reg    = (bus_addr >= ADDR_W'(REG_BASE));
        reg_sel   = bus_addr[3:2];
        buf_en    = bus_req && !is_reg;
        eng_start = bus_req && bus_we && is_reg && (reg_sel == SEL_DIR);
        eng_abort = bus_req && bus_we && is_reg && (reg_sel == SEL_STATUS);

        status_word = '0;
        status_word[0] = eng_done;
        status_word[STAT_ONES_MSB:STAT_ONES_LSB] = '1;
        status_word[STAT_ABORT]  = port_abort_n;
        status_word[STAT_RIP]    = port_rip;
        status_word[STAT_DALIGN] = port_dalign;
        status_word[STAT_CFGERR] = port_cfgerr;

        // clamp the burst so it never runs past the last buffer word
        first_ok   = (regs_q.first < WORD_W'(BUF_WORDS));
        room       = first_ok ? CW'(BUF_WORDS) - CW'(regs_q.first[AW-1:0]) : '0;
        words_over = (regs_q.length >> 2) > WORD_W'(room);
        start_cnt  = words_over ? room : regs_q.length[CW+1:2];

        regs_d          = regs_q;
        regs_d.rvalid   = bus_req && !bus_we;
        regs_d.from_buf = !is_reg;
        if (bus_req && is_reg) begin
            unique case (reg_sel)
                SEL_LENGTH: begin
                    if (bus_we) regs_d.length = bus_wdata;
                    regs_d.rword = regs_q.length;
                end
                SEL_START: begin
                    if (bus_we) regs_d.first = bus_wdata;
                    regs_d.rword = regs_q.first;
                end
                SEL_DIR:    regs_d.rword = '0;
                SEL_STATUS: regs_d.rword = status_word;
                default:    regs_d.rword = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_rvalid = regs_q.rvalid;
    assign bus_rdata  = regs_q.from_buf ? buf_rdata : regs_q.rword;

    cbe_buffer #(.WW(WORD_W), .DEPTH(BUF_WORDS)) u_buffer (
        .clk     (clk),
        .a_en    (buf_en),
        .a_we    (bus_we),
        .a_addr  (bus_addr[AW+1:2]),
        .a_wdata (bus_wdata),
        .a_rdata (buf_rdata),
        .b_en    (b_en),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata)
    );

    cbe_engine #(.WW(WORD_W), .AW(AW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .dir_rb    (bus_wdata[0]),
        .start_off (regs_q.first[AW-1:0]),
        .start_cnt (start_cnt),
        .abort     (eng_abort),
        .done      (eng_done),
        .out_valid (cfg_out_valid),
        .out_data  (cfg_out_data),
        .out_ready (cfg_out_ready),
        .in_valid  (cfg_in_valid),
        .in_data   (cfg_in_data),
        .in_ready  (cfg_in_ready),
        .b_en      (b_en),
        .b_we      (b_we),
        .b_addr    (b_addr),
        .b_wdata   (b_wdata),
        .b_rdata   (b_rdata)
    );
endmodule

// File: rtl/cbe_checks.sv
module cbe_checks #(
    parameter int WW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          start,
    input logic          abort,
    input logic          out_valid,
    input logic          out_ready,
    input logic [WW-1:0] out_data,
    input logic          in_ready,
    input logic          bus_req,
    input logic          bus_we,
    input logic          bus_rvalid
);
    assert_read_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    assert_no_stray_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    assert_word_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !abort) |=> (out_valid && $stable(out_data)));

    assert_one_direction_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, in_ready}));

    assert_done_needs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_abort_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (done && !out_valid && !in_ready));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && !in_ready));
endmodule

bind cfg_burst_engine cbe_checks #(.WW(WORD_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (eng_done),
    .start      (eng_start),
    .abort      (eng_abort),
    .out_valid  (cfg_out_valid),
    .out_ready  (cfg_out_ready),
    .out_data   (cfg_out_data),
    .in_ready   (cfg_in_ready),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_rvalid (bus_rvalid)
);

// File: tb/cfg_burst_engine_test.sv
module cfg_burst_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_rvalid;
    logic        cfg_out_valid, cfg_in_ready;
    logic [31:0] cfg_out_data;
    logic        cfg_out_ready = 1'b0, cfg_in_valid = 1'b0;
    logic [31:0] cfg_in_data = '0;
    logic        port_abort_n = 1'b1, port_rip = 1'b0, port_dalign = 1'b0, port_cfgerr = 1'b0;

    cfg_burst_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cfg_out_valid(cfg_out_valid),
        .cfg_out_data(cfg_out_data), .cfg_out_ready(cfg_out_ready),
        .cfg_in_valid(cfg_in_valid), .cfg_in_data(cfg_in_data),
        .cfg_in_ready(cfg_in_ready), .port_abort_n(port_abort_n),
        .port_rip(port_rip), .port_dalign(port_dalign), .port_cfgerr(port_cfgerr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          n_tests = 0, n_fail = 0;
    logic [31:0] ref_buf [NW];
    logic [31:0] got [NW];
    int          got_n = 0, rb_n = 0, rb_base = 0;
    int          rdy_mode = 0, inv_mode = 0;   // 0 low, 1 high, 2 random
    bit          finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_words(int unsigned len, int unsigned first);
        int unsigned w = len / 4;
        if (first >= NW) return 0;
        if (w > NW - first) return NW - first;
        return w;
    endfunction

    function automatic logic [31:0] exp_status(bit done);
        return {23'd0, port_cfgerr, port_dalign, port_rip, port_abort_n, 4'hF, done};
    endfunction

    // port model: drive at the falling edge, log the handshake due at the next rising edge
    always @(negedge clk) begin
        cfg_out_ready = (rdy_mode == 1) || (rdy_mode == 2 && $urandom_range(1, 0) == 1);
        if (cfg_out_valid && cfg_out_ready) begin
            got[got_n % NW] = cfg_out_data;
            got_n++;
        end
        cfg_in_valid = (inv_mode == 1) || (inv_mode == 2 && $urandom_range(1, 0) == 1);
        cfg_in_data  = $urandom;
        if (cfg_in_valid && cfg_in_ready) begin
            ref_buf[(rb_base + rb_n) % NW] = cfg_in_data;
            rb_n++;
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic v);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s; logic v;
        for (int k = 0; k < 3000; k++) begin
            bus_rd(12'h80C, s, v);
            if (s[0]) return;
        end
        chk(req, 32'd0, 32'd1);
    endtask

    task automatic run_cfg(input int unsigned len, input int unsigned first, input string req);
        int n = exp_words(len, first);
        got_n = 0;
        bus_wr(12'h800, len);
        bus_wr(12'h804, first);
        bus_wr(12'h808, 32'd0);
        wait_done(req);
        chk({req, " count"}, got_n, n);
        for (int i = 0; i < n; i++) chk({req, " data"}, got[i], ref_buf[first + i]);
    endtask

    task automatic run_rb(input int unsigned len, input int unsigned first, input string req);
        int n = exp_words(len, first);
        logic [31:0] d; logic v;
        rb_base = first; rb_n = 0;
        bus_wr(12'h800, len);
        bus_wr(12'h804, first);
        bus_wr(12'h808, 32'd1);
        wait_done(req);
        chk({req, " count"}, rb_n, n);
        for (int i = 0; i < n; i++) begin
            bus_rd(12'((first + i) * 4), d, v);
            chk({req, " stored"}, d, ref_buf[first + i]);
        end
    endtask

    initial begin
        logic [31:0] d; logic v;
        int unsigned seed_val;
        seed_val = $urandom(32'd7319);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 out_valid", cfg_out_valid, 0);
        chk("R11 in_ready", cfg_in_ready, 0);
        bus_rd(12'h800, d, v); chk("R11 length", d, 0);
        bus_rd(12'h804, d, v); chk("R11 start", d, 0);
        bus_rd(12'h80C, d, v); chk("R11 status", d, exp_status(1'b1));

        // R2 registers
        bus_wr(12'h800, 32'hDEAD_BEEF); bus_rd(12'h800, d, v); chk("R2 length", d, 32'hDEAD_BEEF);
        bus_wr(12'h804, 32'h1234_5678); bus_rd(12'h804, d, v); chk("R2 start", d, 32'h1234_5678);
        bus_rd(12'h808, d, v); chk("R2 dir reads 0", d, 0);

        // R1 buffer fill and read back
        for (int i = 0; i < NW; i++) begin
            ref_buf[i] = $urandom;
            bus_wr(12'(i * 4), ref_buf[i]);
        end
        bus_rd(12'h000, d, v); chk("R1 word0", d, ref_buf[0]); chk("R1 rvalid", v, 1);
        bus_rd(12'h7FC, d, v); chk("R1 word511", d, ref_buf[511]);
        for (int k = 0; k < 6; k++) begin
            int a = $urandom_range(NW - 1, 0);
            bus_rd(12'(a * 4), d, v); chk("R1 random word", d, ref_buf[a]);
        end

        // R4 status packing
        for (int k = 0; k < 4; k++) begin
            {port_abort_n, port_rip, port_dalign, port_cfgerr} = 4'($urandom);
            bus_rd(12'h80C, d, v); chk("R4 status", d, exp_status(1'b1));
        end
        {port_abort_n, port_rip, port_dalign, port_cfgerr} = 4'b1000;

        // R3/R5 directed configure, low length bits ignored
        rdy_mode = 1;
        run_cfg(10 * 4 + 3, 3, "R3 R5 directed");
        // R5 random configure with random ready
        rdy_mode = 2;
        for (int k = 0; k < 6; k++) begin
            int unsigned f = $urandom_range(NW - 1, 0);
            run_cfg($urandom_range(40, 1) * 4 + $urandom_range(3, 0), f, "R5 random");
        end

        // R6 readback
        inv_mode = 1; run_rb(20 * 4, 100, "R6 directed");
        inv_mode = 2;
        for (int k = 0; k < 3; k++) run_rb($urandom_range(30, 1) * 4, $urandom_range(480, 0), "R6 random");
        inv_mode = 0;

        // R7 clamp
        rdy_mode = 2;
        run_cfg(20 * 4, 505, "R7 clamp");
        run_cfg(8 * 4, 600, "R7 out of range");
        inv_mode = 2; run_rb(40 * 4, 500, "R7 readback clamp"); inv_mode = 0;

        // R8 zero length: done stays 1 in the cycle after the start
        got_n = 0;
        bus_wr(12'h800, 32'd3);
        bus_wr(12'h804, 32'd0);
        bus_wr(12'h808, 32'd0);
        bus_rd(12'h80C, d, v); chk("R8 done stays", d[0], 1);
        repeat (4) @(negedge clk);
        chk("R8 no handshake", got_n, 0);

        // R9 second start while busy; R3 busy shows done 0
        rdy_mode = 0; inv_mode = 1; got_n = 0; rb_n = 0; rb_base = 0;
        bus_wr(12'h800, 32'd16);
        bus_wr(12'h804, 32'd0);
        bus_wr(12'h808, 32'd0);
        bus_rd(12'h80C, d, v); chk("R3 busy", d[0], 0);
        bus_wr(12'h808, 32'd1);
        repeat (3) @(negedge clk);
        rdy_mode = 1;
        wait_done("R9 finish");
        chk("R9 readback ignored", rb_n, 0);
        chk("R9 configure count", got_n, 4);
        inv_mode = 0;

        // R10 abort of a stalled configure
        rdy_mode = 0; got_n = 0;
        bus_wr(12'h800, 32'd40);
        bus_wr(12'h804, 32'd8);
        bus_wr(12'h808, 32'd0);
        repeat (3) @(negedge clk);
        bus_wr(12'h80C, 32'h0000_FEFE);
        chk("R10 out_valid low", cfg_out_valid, 0);
        rdy_mode = 1;
        repeat (4) @(negedge clk);
        chk("R10 no handshake", got_n, 0);
        bus_rd(12'h80C, d, v); chk("R10 done", d[0], 1);

        // R10 abort in the same cycle as a readback handshake
        rdy_mode = 0; inv_mode = 1; rb_base = 200; rb_n = 0;
        bus_wr(12'h800, 32'd200);
        bus_wr(12'h804, 32'd200);
        bus_wr(12'h808, 32'd1);
        repeat (5) @(negedge clk);
        bus_wr(12'h80C, 32'h0000_FEFE);
        inv_mode = 0;
        chk("R10 in_ready low", cfg_in_ready, 0);
        chk("R10 partial count", 32'(rb_n < 50 && rb_n > 0), 1);
        for (int i = 0; i <= rb_n; i++) begin
            bus_rd(12'((200 + i) * 4), d, v);
            chk("R10 stored around abort", d, ref_buf[200 + i]);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule